// File: doc/BRIEF.md
# Atomic 64-Byte Store Execution Unit

This unit carries out one store-with-status instruction. It takes a 32-bit instruction word and checks it against the fixed opcode pattern. It then takes three register numbers from the word: status, base and first data register. Through a single register-file read port it fetches the base address, or takes the stack pointer instead. After that it collects eight consecutive 64-bit registers into one 512-bit line.

The whole line goes out as one indivisible write on a valid/ready memory request channel. A one-cycle response reports whether the write took effect. The unit then writes a status of 0 (stored) or 1 (rejected) back to the status register. Operand and alignment problems end the instruction early, with a fault pulse and no memory traffic.

Top module: `ls64_store_unit`

## Requirements
- R1: A word is accepted only while the unit is idle and when (word & 0xFFE0FC00) == 0xF820B000. The status register number sits in bits [20:16], the base in bits [9:5] and the first data register in bits [4:0]. A word that does not match is ignored: busy stays low and no done pulse follows.
- R2: Register t+i fills line bits [64*i+63 : 64*i] of the memory write, for i = 0 to 7.
- R3: When big_endian is 1 at acceptance, the bytes of each doubleword are reversed before packing: byte 0 swaps with byte 7, and so on.
- R4: Base number 31 selects sp_value as the address. Any other number selects that general register's value.
- R5: With base 31 and sp_value[3:0] != 0, fault_sp_align pulses together with done, and no memory request or writeback occurs.
- R6: An address with bits [5:0] != 0 pulses fault_align together with done, and no memory request or writeback occurs. Every issued request address has bits [5:0] == 0.
- R7: A first data register that is odd or greater than 23 pulses fault_operand and makes no memory access. The priority is operand fault, then stack-pointer fault, then alignment fault, and at most one fault flag is high.
- R8: On completion the status written is 0 when mem_rsp_fail is 0 and 1 when it is 1. It goes to the status register number, with wb_valid high for one cycle in the same cycle as done.
- R9: With status register number 31, no writeback happens and done still pulses.
- R10: A rejected write leaves memory unchanged. The request address and data hold steady while mem_req_valid is high and mem_req_ready is low.
- R11: busy is high from the cycle after acceptance and is low in the cycle where done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction word present |
| instr_word | input | 32 | Instruction word |
| big_endian | input | 1 | Byte-reverse each doubleword |
| sp_value | input | 64 | Stack pointer value |
| busy | output | 1 | Instruction in progress |
| rf_rd_addr | output | 5 | Register-file read number |
| rf_rd_data | input | 64 | Register-file read data, same cycle |
| mem_req_valid | output | 1 | Line write request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 64 | Line address |
| mem_req_data | output | 512 | Line data |
| mem_rsp_valid | input | 1 | Response pulse |
| mem_rsp_fail | input | 1 | Write rejected |
| wb_valid | output | 1 | Status writeback strobe |
| wb_addr | output | 5 | Status register number |
| wb_data | output | 64 | Status value |
| done | output | 1 | Instruction finished |
| fault_operand | output | 1 | Illegal data register range |
| fault_sp_align | output | 1 | Stack pointer misaligned |
| fault_align | output | 1 | Line address misaligned |

## Verification
The hardest case to reach is a write the memory rejects. From the unit's side a rejected write looks just like an accepted one until the response arrives. The check is only meaningful if the memory line stays intact. The bench memory model has a force-fail control that is set before the instruction is driven. The scoreboard records the target line as it stood beforehand and compares it after the status of 1 comes back. Fault priority is reached with operand values that break several rules at once, such as an illegal data register together with a misaligned base.

// File: rtl/ls64_pkg.sv
package ls64_pkg;
   localparam int XLEN      = 64;
   localparam int LANES     = 8;
   localparam int LINE_W    = XLEN * LANES;
   localparam int RNUM_W    = 5;
   localparam logic [31:0] OPC_MASK  = 32'hFFE0FC00;
   localparam logic [31:0] OPC_MATCH = 32'hF820B000;
   localparam logic [RNUM_W-1:0] RNUM_SP = 5'd31;
   localparam logic [RNUM_W-1:0] RT_MAX  = RNUM_W'(31 - LANES);
   localparam logic [XLEN-1:0]   STATUS_FAIL = XLEN'(1);

   typedef enum logic [2:0] {
      ST_IDLE, ST_BASE, ST_GATHER, ST_REQ, ST_RESP
   } ls_state_t;

   function automatic logic [XLEN-1:0] dw_byte_rev(input logic [XLEN-1:0] v);
      logic [XLEN-1:0] r;
      for (int b = 0; b < XLEN/8; b++)
         r[8*b +: 8] = v[XLEN-8-8*b +: 8];
      return r;
   endfunction
endpackage

// File: rtl/ls64_line_pack.sv
module ls64_line_pack #(
   parameter int DW    = 64,
   parameter int LANES = 8,
   localparam int IDX_W = $clog2(LANES)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load_en,
   input  logic [IDX_W-1:0]    lane_idx,
   input  logic                swap,
   input  logic [DW-1:0]       word,
   output logic [DW*LANES-1:0] line
);
   logic [DW-1:0] swapped;

   generate
      if (DW % 8 != 0) begin : g_bad_dw
         $error("ls64_line_pack: DW must be a whole number of bytes");
      end
      for (genvar b = 0; b < DW/8; b++) begin : g_rev
         assign swapped[8*b +: 8] = word[DW-8-8*b +: 8];
      end
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         logic [DW-1:0] lane_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               lane_q <= '0;
            else if (load_en && lane_idx == IDX_W'(g))
               lane_q <= swap ? swapped : word;
         end
         assign line[DW*g +: DW] = lane_q;
      end
   endgenerate
endmodule

// File: rtl/ls64_addr_check.sv
module ls64_addr_check #(
   parameter int AW            = 64,
   parameter int LINE_ALIGN    = 6,
   parameter int SP_ALIGN      = 4
) (
   input  logic          use_sp,
   input  logic [AW-1:0] sp_value,
   input  logic [AW-1:0] gpr_value,
   output logic [AW-1:0] addr,
   output logic          sp_bad,
   output logic          line_bad
);
   generate
      if (SP_ALIGN > LINE_ALIGN || LINE_ALIGN >= AW) begin : g_bad_align
         $error("ls64_addr_check: alignment widths out of range");
      end
   endgenerate

   assign addr     = use_sp ? sp_value : gpr_value;
   assign sp_bad   = use_sp && (sp_value[SP_ALIGN-1:0] != '0);
   assign line_bad = addr[LINE_ALIGN-1:0] != '0;
endmodule

// File: rtl/ls64_store_unit.sv
module ls64_store_unit
   import ls64_pkg::*;
#(
   parameter int SP_ALIGN_BITS = 4,
   localparam int LINE_BYTES   = LINE_W / 8,
   localparam int ALIGN_BITS   = $clog2(LINE_BYTES),
   localparam int CNT_W        = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_valid,
   input  logic [31:0]       instr_word,
   input  logic              big_endian,
   input  logic [XLEN-1:0]   sp_value,
   output logic              busy,
   output logic [RNUM_W-1:0] rf_rd_addr,
   input  logic [XLEN-1:0]   rf_rd_data,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [XLEN-1:0]   mem_req_addr,
   output logic [LINE_W-1:0] mem_req_data,
   input  logic              mem_rsp_valid,
   input  logic              mem_rsp_fail,
   output logic              wb_valid,
   output logic [RNUM_W-1:0] wb_addr,
   output logic [XLEN-1:0]   wb_data,
   output logic              done,
   output logic              fault_operand,
   output logic              fault_sp_align,
   output logic              fault_align
);
   generate
      if ((LANES & (LANES - 1)) != 0) begin : g_bad_lanes
         $error("ls64_store_unit: LANES must be a power of two");
      end
   endgenerate

   ls_state_t         st_q;
   logic [RNUM_W-1:0] rs_q, rn_q, rt_q;
   logic              be_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [XLEN-1:0]   addr_q;
   logic              accept, op_bad;
   logic [XLEN-1:0]   sel_addr;
   logic              sp_bad, line_bad;

   assign accept = (st_q == ST_IDLE) && instr_valid &&
                   ((instr_word & OPC_MASK) == OPC_MATCH);
   assign op_bad = rt_q[0] || (rt_q > RT_MAX);
   assign busy   = (st_q != ST_IDLE);
   assign rf_rd_addr = (st_q == ST_GATHER) ? rt_q + RNUM_W'(cnt_q) : rn_q;

   ls64_addr_check #(
      .AW(XLEN), .LINE_ALIGN(ALIGN_BITS), .SP_ALIGN(SP_ALIGN_BITS)
   ) addr_i (
      .use_sp    (rn_q == RNUM_SP),
      .sp_value  (sp_value),
      .gpr_value (rf_rd_data),
      .addr      (sel_addr),
      .sp_bad    (sp_bad),
      .line_bad  (line_bad)
   );

   ls64_line_pack #(.DW(XLEN), .LANES(LANES)) pack_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (st_q == ST_GATHER),
      .lane_idx (cnt_q),
      .swap     (be_q),
      .word     (rf_rd_data),
      .line     (mem_req_data)
   );

   assign mem_req_valid = (st_q == ST_REQ);
   assign mem_req_addr  = addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
         rs_q <= '0; rn_q <= '0; rt_q <= '0; be_q <= 1'b0;
         cnt_q <= '0; addr_q <= '0;
         wb_valid <= 1'b0; wb_addr <= '0; wb_data <= '0;
         done <= 1'b0;
         fault_operand <= 1'b0; fault_sp_align <= 1'b0; fault_align <= 1'b0;
      end else begin
         wb_valid       <= 1'b0;
         done           <= 1'b0;
         fault_operand  <= 1'b0;
         fault_sp_align <= 1'b0;
         fault_align    <= 1'b0;
         unique case (st_q)
            ST_IDLE: if (accept) begin
               rs_q <= instr_word[20:16];
               rn_q <= instr_word[9:5];
               rt_q <= instr_word[4:0];
               be_q <= big_endian;
               st_q <= ST_BASE;
            end
            ST_BASE: begin
               if (op_bad || sp_bad || line_bad) begin
                  fault_operand  <= op_bad;
                  fault_sp_align <= !op_bad && sp_bad;
                  fault_align    <= !op_bad && !sp_bad;
                  done           <= 1'b1;
                  st_q           <= ST_IDLE;
               end else begin
                  addr_q <= sel_addr;
                  cnt_q  <= '0;
                  st_q   <= ST_GATHER;
               end
            end
            ST_GATHER: begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == CNT_W'(LANES - 1)) st_q <= ST_REQ;
            end
            ST_REQ: if (mem_req_ready) st_q <= ST_RESP;
            ST_RESP: if (mem_rsp_valid) begin
               wb_valid <= (rs_q != RNUM_SP);
               wb_addr  <= rs_q;
               wb_data  <= mem_rsp_fail ? STATUS_FAIL : '0;
               done     <= 1'b1;
               st_q     <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_data)); // R10
   AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> mem_req_addr[ALIGN_BITS-1:0] == '0); // R6
   AST_NO_WB_R31: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> wb_addr != RNUM_SP); // R9
   AST_ONE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fault_operand, fault_sp_align, fault_align})); // R7
   AST_STATUS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> (wb_data == '0 || wb_data == STATUS_FAIL)); // R8
   AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R11
   AST_FAULT_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_operand || fault_sp_align || fault_align) |-> done && !wb_valid); // R5
endmodule

// File: tb/ls64_store_unit_tb_top.sv
module ls64_store_unit_tb_top;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic         instr_valid = 1'b0;
   logic [31:0]  instr_word = '0;
   logic         big_endian = 1'b0;
   logic [63:0]  sp_value = '0;
   logic         busy;
   logic [4:0]   rf_rd_addr;
   logic [63:0]  rf_rd_data;
   logic         mem_req_valid, mem_req_ready;
   logic [63:0]  mem_req_addr;
   logic [511:0] mem_req_data;
   logic         mem_rsp_valid, mem_rsp_fail;
   logic         wb_valid, done, fault_operand, fault_sp_align, fault_align;
   logic [4:0]   wb_addr;
   logic [63:0]  wb_data;

   logic [63:0]  regs [32];
   logic [511:0] mem [16];
   logic         force_fail = 1'b0;
   int           req_count = 0;
   int           dly = 0;
   int           errors = 0;
   int           checks = 0;

   assign rf_rd_data = regs[rf_rd_addr];

   ls64_store_unit dut_i (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
      .big_endian(big_endian), .sp_value(sp_value), .busy(busy),
      .rf_rd_addr(rf_rd_addr), .rf_rd_data(rf_rd_data),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_fail(mem_rsp_fail),
      .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data), .done(done),
      .fault_operand(fault_operand), .fault_sp_align(fault_sp_align),
      .fault_align(fault_align)
   );

   // memory model: ready after a short wait, one response pulse, write only on success
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_req_ready <= 1'b0; mem_rsp_valid <= 1'b0; mem_rsp_fail <= 1'b0; dly <= 0;
      end else begin
         mem_rsp_valid <= 1'b0;
         if (mem_req_valid && mem_req_ready) begin
            req_count <= req_count + 1;
            if (!force_fail) mem[mem_req_addr[9:6]] <= mem_req_data;
            mem_rsp_valid <= 1'b1;
            mem_rsp_fail  <= force_fail;
            mem_req_ready <= 1'b0;
            dly <= 0;
         end else if (mem_req_valid) begin
            dly <= dly + 1;
            mem_req_ready <= (dly >= 1);
         end
      end
   end

   typedef struct {
      string        tag;
      logic [2:0]   flt;     // {operand, sp, align}
      logic         wb;
      logic [4:0]   wb_addr;
      logic [63:0]  status;
      logic [3:0]   idx;
      logic [511:0] line;
      int           reqs;
   } exp_t;
   exp_t q[$];
   int exp_reqs = 0;

   task automatic chk(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] rev8(input logic [63:0] v);
      logic [63:0] r;
      for (int b = 0; b < 8; b++) r[8*b +: 8] = v[56-8*b +: 8];
      return r;
   endfunction

   // driver: computes expectations from the requirements and pushes them
   task automatic run(input string tag, input logic [4:0] rs, input logic [4:0] rn,
                      input logic [4:0] rt, input bit be, input bit fail, input logic [63:0] base);
      exp_t e;
      logic [63:0] a;
      if (rn == 5'd31) sp_value = base; else regs[rn] = base;
      a = base;
      e.tag = tag;
      e.idx = a[9:6];
      e.flt = 3'b000;
      if (rt[0] || rt > 5'd23) e.flt = 3'b100;
      else if (rn == 5'd31 && a[3:0] != 0) e.flt = 3'b010;
      else if (a[5:0] != 0) e.flt = 3'b001;
      e.line = mem[e.idx];
      e.wb = 1'b0; e.wb_addr = rs; e.status = fail ? 64'd1 : 64'd0;
      if (e.flt == 3'b000) begin
         exp_reqs++;
         e.wb = (rs != 5'd31);
         if (!fail)
            for (int i = 0; i < 8; i++)
               e.line[64*i +: 64] = be ? rev8(regs[rt + 5'(i)]) : regs[rt + 5'(i)];
      end
      e.reqs = exp_reqs;
      force_fail = fail;
      q.push_back(e);
      @(negedge clk);
      instr_word  = 32'hF820B000 | (32'(rs) << 16) | (32'(rn) << 5) | 32'(rt);
      big_endian  = be;
      instr_valid = 1'b1;
      @(negedge clk);
      instr_valid = 1'b0;
      chk(busy === 1'b1, {"R11 busy after accept ", tag}, busy, 1);
      while (q.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   // monitor: compares each completion with the scoreboard head
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && done) begin
            if (q.size() == 0) chk(0, "R1 unexpected done", 1, 0);
            else begin
               exp_t e;
               e = q.pop_front();
               chk({fault_operand, fault_sp_align, fault_align} === e.flt,
                   {"R5 R6 R7 fault flags ", e.tag}, {fault_operand, fault_sp_align, fault_align}, e.flt);
               chk(wb_valid === e.wb, {"R9 wb_valid ", e.tag}, wb_valid, e.wb);
               if (e.wb) begin
                  chk(wb_addr === e.wb_addr, {"R8 wb_addr ", e.tag}, wb_addr, e.wb_addr);
                  chk(wb_data === e.status, {"R8 status ", e.tag}, wb_data, e.status);
               end
               chk(mem[e.idx] === e.line, {"R2 R3 R10 memory line ", e.tag}, mem[e.idx], e.line);
               chk(req_count == e.reqs, {"R6 request count ", e.tag}, req_count, e.reqs);
               chk(busy === 1'b0, {"R11 busy at done ", e.tag}, busy, 0);
            end
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired R11 actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      for (int i = 0; i < 32; i++) regs[i] = 64'h0102030405060708 * 64'(i + 1) ^ 64'hF0E1D2C3B4A59687;
      for (int i = 0; i < 16; i++) mem[i] = {16{32'hDEAD0000 | 32'(i)}};
      repeat (3) @(negedge clk);
      chk(busy === 1'b0 && mem_req_valid === 1'b0 && done === 1'b0, "R11 reset state", busy, 0);
      rst_n = 1'b1;
      @(negedge clk);

      run("le_basic",    5'd5,  5'd30, 5'd0,  1'b0, 1'b0, 64'h40);   // R2 R4 R8
      run("be_swap",     5'd7,  5'd30, 5'd8,  1'b1, 1'b0, 64'h80);   // R3
      run("sp_base",     5'd9,  5'd31, 5'd2,  1'b0, 1'b0, 64'h100);  // R4
      run("forced_fail", 5'd10, 5'd30, 5'd4,  1'b0, 1'b1, 64'hC0);   // R8 R10
      run("rs31_nowb",   5'd31, 5'd30, 5'd6,  1'b1, 1'b0, 64'h140);  // R9
      run("gpr_misalign",5'd11, 5'd30, 5'd0,  1'b0, 1'b0, 64'h48);   // R6
      run("sp_misalign", 5'd12, 5'd31, 5'd0,  1'b0, 1'b0, 64'h108);  // R5
      run("sp_line_mis", 5'd12, 5'd31, 5'd0,  1'b0, 1'b0, 64'h110);  // R6
      run("rt_odd",      5'd13, 5'd30, 5'd3,  1'b0, 1'b0, 64'h180);  // R7
      run("rt_high_mis", 5'd13, 5'd30, 5'd24, 1'b0, 1'b0, 64'h1C4);  // R7 priority
      run("rt_top",      5'd14, 5'd30, 5'd22, 1'b1, 1'b0, 64'h200);  // R2 R3 R7 edge
      force_fail = 1'b0;

      // R1: a word outside the opcode pattern is ignored
      @(negedge clk);
      instr_word = 32'hF820B000 ^ 32'h00000400; // bit 10 flipped
      instr_valid = 1'b1;
      @(negedge clk);
      instr_valid = 1'b0;
      chk(busy === 1'b0, "R1 bad opcode ignored busy", busy, 0);
      repeat (15) begin
         @(negedge clk);
         chk(done === 1'b0 && mem_req_valid === 1'b0, "R1 bad opcode no activity", done, 0);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule